// File: doc/BRIEF.md
# CCM First Block and Counter Generator

This block prepares the three 128-bit blocks that a CCM authenticated-encryption sequence needs before the cipher engine runs: the first authentication block, the initial counter block used for payload keystream, and the counter block used to encrypt the tag. A request carries the nonce (0 to 15 bytes, with a separate byte count), the tag length in bytes, a 32-bit payload length and a flag telling whether associated data follows. The generator checks the request and then fills the three blocks one byte position per cycle, with all three blocks written at each position. It pulses a one-cycle completion strobe once every position is written.

The request side is a valid/ready handshake. `req_ready` is high only while no build is in progress. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. The requester may hold `req_valid` high for any length of time, and its fields must stay steady until the handshake completes. The result side has no back-pressure. The blocks hold their values from the completion strobe until the next accepted request, and any consumer reads them in that window. Each block can be read as a whole vector or one 32-bit word at a time through a shared word selector.

Byte 0 of every block is its most significant byte (bits 127:120). Nonce byte k sits at `nonce_i[119-8k -: 8]`. Word 0 is bits 127:96.

Top module: `ccm_block_gen`

## Requirements
- R1: Bit 6 of the first-block flags byte (byte 0) is 1 exactly when `has_aad_i` was 1 in the accepted request.
- R2: Bits 5:3 of the flags byte equal (tag length − 2) / 2.
- R3: Bits 2:0 of the flags byte equal the low three bits of (14 − nonce length), and bit 7 is 0.
- R4: First-block bytes 1 through the nonce length hold nonce bytes 0 through length−1, in order.
- R5: Every first-block byte after the nonce at position p holds payload-length byte (15 − p), counted from the least significant byte, when 15 − p < 4; otherwise it is zero. The length therefore appears most significant byte first, capped at four bytes.
- R6: The initial counter block holds the flags' low three bits in byte 0, the nonce in bytes 1 through the nonce length, and zeros elsewhere. Its bit 0 (byte 15 bit 0) is forced to 1.
- R7: The tag counter block equals the initial counter block with bit 0 cleared.
- R8: A request with a nonce length above 15 sets `err_o`, produces no completion strobe, and leaves all three blocks unchanged.
- R9: A request whose tag length is odd, below 4 or above 16 sets `err_o`, produces no completion strobe, and leaves all three blocks unchanged. A later valid request clears `err_o`.
- R10: After an accepted valid request, `req_ready` stays low for 16 cycles. `done_o` is high for exactly one cycle, namely the 17th cycle after the accepting edge, and `req_ready` is high again in that same cycle.
- R11: While idle, the blocks do not change. `word_sel_i` = w places bits [127−32w -: 32] of each block on the matching word output.
- R12: After reset, `req_ready` is 1, `done_o` and `err_o` are 0, and all blocks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle and able to take a request |
| nonce_i | input | 120 | Nonce bytes, byte 0 most significant |
| nonce_len_i | input | 5 | Nonce length in bytes |
| tag_len_i | input | 5 | Tag length in bytes |
| payload_len_i | input | 32 | Payload length in bytes |
| has_aad_i | input | 1 | Associated data present |
| word_sel_i | input | 2 | Word index for the word outputs |
| b0_o | output | 128 | First authentication block |
| ctr0_o | output | 128 | Initial counter block |
| ctr_tag_o | output | 128 | Tag-phase counter block |
| b0_word_o | output | 32 | Selected word of the first block |
| ctr0_word_o | output | 32 | Selected word of the initial counter |
| ctr_tag_word_o | output | 32 | Selected word of the tag counter |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Last accepted request was rejected |

## Verification
The completion strobe of one job and the acceptance of the next request can fall in the same cycle, because `req_ready` returns together with `done_o`. The bench provokes this by presenting a second request while the first is still building and holding `req_valid` high. The handshake then completes on the edge that ends the strobe cycle. The bench judges it by comparing the first job's blocks during the strobe cycle, checking that `req_ready` falls right after the overlapping edge, and checking that the second job's blocks appear 17 cycles later, unaffected by the first.

// File: rtl/ccm_gen_pkg.sv
package ccm_gen_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_BUILD = 1'b1
  } gen_state_e;

  localparam int FLAG_AAD_BIT = 6;
endpackage

// File: rtl/ccm_req_check.sv
module ccm_req_check #(
  parameter int NONCE_BYTES = 15,
  parameter int NL_W        = 5,
  parameter int TAG_W       = 5
) (
  input  logic [NL_W-1:0]  nonce_len,
  input  logic [TAG_W-1:0] tag_len,
  input  logic             has_aad,
  output logic             req_ok,
  output logic [7:0]       flags
);
  localparam int MAX_TAG = NONCE_BYTES + 1;

  logic [TAG_W-1:0] tag_less2;
  logic [NL_W-1:0]  q_less1;
  logic             nonce_ok;
  logic             tag_ok;

  always_comb begin
    nonce_ok  = (nonce_len <= NL_W'(NONCE_BYTES));
    tag_ok    = !tag_len[0] && (tag_len >= TAG_W'(4)) && (tag_len <= TAG_W'(MAX_TAG));
    req_ok    = nonce_ok && tag_ok;
    tag_less2 = tag_len - TAG_W'(2);
    q_less1   = NL_W'(NONCE_BYTES - 1) - nonce_len;
    flags     = 8'h00;
    flags[ccm_gen_pkg::FLAG_AAD_BIT] = has_aad;
    flags[5:3] = tag_less2[3:1];
    flags[2:0] = q_less1[2:0];
  end
endmodule

// File: rtl/ccm_byte_pick.sv
module ccm_byte_pick #(
  parameter int NONCE_BYTES = 15,
  parameter int LEN_W       = 32,
  parameter int POS_W       = 4
) (
  input  logic [POS_W-1:0]         pos,
  input  logic [POS_W-1:0]         nonce_len,
  input  logic [8*NONCE_BYTES-1:0] nonce,
  input  logic [LEN_W-1:0]         payload_len,
  input  logic [7:0]               flags,
  output logic [7:0]               b0_byte,
  output logic [7:0]               ctr0_byte,
  output logic [7:0]               ctr_tag_byte
);
  localparam int BLK_BYTES = NONCE_BYTES + 1;
  localparam int LEN_BYTES = LEN_W / 8;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK_BYTES - 1);

  int         nonce_idx;
  int         tail;
  int         len_idx;
  logic [7:0] nonce_byte;
  logic [7:0] len_byte;
  logic [7:0] ctr_base;

  always_comb begin
    nonce_idx  = (pos == '0) ? 0 : (NONCE_BYTES - int'(pos));
    nonce_byte = nonce[8*nonce_idx +: 8];
    tail       = BLK_BYTES - 1 - int'(pos);
    len_idx    = (tail < LEN_BYTES) ? tail : 0;
    len_byte   = (tail < LEN_BYTES) ? payload_len[8*len_idx +: 8] : 8'h00;

    if (pos == '0) begin
      b0_byte  = flags;
      ctr_base = {5'b00000, flags[2:0]};
    end else if (pos <= nonce_len) begin
      b0_byte  = nonce_byte;
      ctr_base = nonce_byte;
    end else begin
      b0_byte  = len_byte;
      ctr_base = 8'h00;
    end

    ctr0_byte    = (pos == LAST_POS) ? (ctr_base | 8'h01) : ctr_base;
    ctr_tag_byte = (pos == LAST_POS) ? (ctr_base & 8'hFE) : ctr_base;
  end
endmodule

// File: rtl/ccm_block_regs.sv
module ccm_block_regs #(
  parameter int BLK_BYTES = 16,
  parameter int POS_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [POS_W-1:0]       pos,
  input  logic [7:0]             b0_byte,
  input  logic [7:0]             ctr0_byte,
  input  logic [7:0]             ctr_tag_byte,
  output logic [8*BLK_BYTES-1:0] b0_blk,
  output logic [8*BLK_BYTES-1:0] ctr0_blk,
  output logic [8*BLK_BYTES-1:0] ctr_tag_blk
);
  logic [7:0] b0_a   [BLK_BYTES];
  logic [7:0] c0_a   [BLK_BYTES];
  logic [7:0] ct_a   [BLK_BYTES];

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b0_a[g] <= 8'h00;
        c0_a[g] <= 8'h00;
        ct_a[g] <= 8'h00;
      end else if (wr_en && (pos == POS_W'(g))) begin
        b0_a[g] <= b0_byte;
        c0_a[g] <= ctr0_byte;
        ct_a[g] <= ctr_tag_byte;
      end
    end

    assign b0_blk[8*(BLK_BYTES-1-g) +: 8]      = b0_a[g];
    assign ctr0_blk[8*(BLK_BYTES-1-g) +: 8]    = c0_a[g];
    assign ctr_tag_blk[8*(BLK_BYTES-1-g) +: 8] = ct_a[g];
  end
endmodule

// File: rtl/ccm_block_gen.sv
module ccm_block_gen #(
  parameter int NONCE_BYTES = 15,
  parameter int LEN_W       = 32,
  parameter int WORD_W      = 32,
  parameter int NL_W        = 5,
  parameter int TAG_W       = 5,
  localparam int BLK_BYTES  = NONCE_BYTES + 1,
  localparam int BLK_W      = 8 * BLK_BYTES,
  localparam int WORDS      = BLK_W / WORD_W,
  localparam int SEL_W      = $clog2(WORDS),
  localparam int NONCE_W    = 8 * NONCE_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic [NL_W-1:0]    nonce_len_i,
  input  logic [TAG_W-1:0]   tag_len_i,
  input  logic [LEN_W-1:0]   payload_len_i,
  input  logic               has_aad_i,
  input  logic [SEL_W-1:0]   word_sel_i,
  output logic [BLK_W-1:0]   b0_o,
  output logic [BLK_W-1:0]   ctr0_o,
  output logic [BLK_W-1:0]   ctr_tag_o,
  output logic [WORD_W-1:0]  b0_word_o,
  output logic [WORD_W-1:0]  ctr0_word_o,
  output logic [WORD_W-1:0]  ctr_tag_word_o,
  output logic               done_o,
  output logic               err_o
);
  import ccm_gen_pkg::*;

  localparam int POS_W = $clog2(BLK_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK_BYTES - 1);

  gen_state_e         state_q;
  logic [POS_W-1:0]   pos_q;
  logic [POS_W-1:0]   nlen_q;
  logic [NONCE_W-1:0] nonce_q;
  logic [LEN_W-1:0]   plen_q;
  logic [7:0]         flags_q;
  logic               done_q;
  logic               err_q;

  logic               req_ok;
  logic [7:0]         flags_c;
  logic               accept;
  logic               building;
  logic [7:0]         b0_byte;
  logic [7:0]         ctr0_byte;
  logic [7:0]         ctr_tag_byte;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign building  = (state_q == ST_BUILD);

  ccm_req_check #(.NONCE_BYTES(NONCE_BYTES), .NL_W(NL_W), .TAG_W(TAG_W)) u_check (
    .nonce_len (nonce_len_i),
    .tag_len   (tag_len_i),
    .has_aad   (has_aad_i),
    .req_ok    (req_ok),
    .flags     (flags_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      nlen_q  <= '0;
      nonce_q <= '0;
      plen_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        err_q <= !req_ok;
        if (req_ok) begin
          state_q <= ST_BUILD;
          pos_q   <= '0;
          nlen_q  <= nonce_len_i[POS_W-1:0];
          nonce_q <= nonce_i;
          plen_q  <= payload_len_i;
          flags_q <= flags_c;
        end
      end else if (building) begin
        pos_q <= pos_q + POS_W'(1);
        if (pos_q == LAST_POS) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  ccm_byte_pick #(.NONCE_BYTES(NONCE_BYTES), .LEN_W(LEN_W), .POS_W(POS_W)) u_pick (
    .pos          (pos_q),
    .nonce_len    (nlen_q),
    .nonce        (nonce_q),
    .payload_len  (plen_q),
    .flags        (flags_q),
    .b0_byte      (b0_byte),
    .ctr0_byte    (ctr0_byte),
    .ctr_tag_byte (ctr_tag_byte)
  );

  ccm_block_regs #(.BLK_BYTES(BLK_BYTES), .POS_W(POS_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (building),
    .pos          (pos_q),
    .b0_byte      (b0_byte),
    .ctr0_byte    (ctr0_byte),
    .ctr_tag_byte (ctr_tag_byte),
    .b0_blk       (b0_o),
    .ctr0_blk     (ctr0_o),
    .ctr_tag_blk  (ctr_tag_o)
  );

  always_comb begin
    b0_word_o      = b0_o[WORD_W*(WORDS-1-int'(word_sel_i)) +: WORD_W];
    ctr0_word_o    = ctr0_o[WORD_W*(WORDS-1-int'(word_sel_i)) +: WORD_W];
    ctr_tag_word_o = ctr_tag_o[WORD_W*(WORDS-1-int'(word_sel_i)) +: WORD_W];
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/ccm_block_gen_chk.sv
module ccm_block_gen_chk #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done_o,
  input logic             err_o,
  input logic [BLK_W-1:0] b0_o,
  input logic [BLK_W-1:0] ctr0_o,
  input logic [BLK_W-1:0] ctr_tag_o
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready); // R10
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(b0_o) && $stable(ctr0_o) && $stable(ctr_tag_o))); // R11
  AST_CTR_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctr0_o[0] && !ctr_tag_o[0])); // R6
  AST_CTR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctr0_o[BLK_W-1 -: 8] == {5'b00000, b0_o[BLK_W-6 -: 3]})); // R6
  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctr_tag_o[BLK_W-1:1] == ctr0_o[BLK_W-1:1])); // R7
  AST_FLAG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !b0_o[BLK_W-1]); // R3
endmodule

bind ccm_block_gen ccm_block_gen_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done_o    (done_o),
  .err_o     (err_o),
  .b0_o      (b0_o),
  .ctr0_o    (ctr0_o),
  .ctr_tag_o (ctr_tag_o)
);

// File: tb/ccm_block_gen_bench.sv
`timescale 1ns/1ps
module ccm_block_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [119:0] nonce_i;
  logic [4:0]   nonce_len_i;
  logic [4:0]   tag_len_i;
  logic [31:0]  payload_len_i;
  logic         has_aad_i;
  logic [1:0]   word_sel_i;
  logic [127:0] b0_o, ctr0_o, ctr_tag_o;
  logic [31:0]  b0_word_o, ctr0_word_o, ctr_tag_word_o;
  logic         done_o, err_o;

  always #2 clk = ~clk;

  ccm_block_gen u_ccm_block_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .nonce_i(nonce_i), .nonce_len_i(nonce_len_i), .tag_len_i(tag_len_i),
    .payload_len_i(payload_len_i), .has_aad_i(has_aad_i), .word_sel_i(word_sel_i),
    .b0_o(b0_o), .ctr0_o(ctr0_o), .ctr_tag_o(ctr_tag_o),
    .b0_word_o(b0_word_o), .ctr0_word_o(ctr0_word_o), .ctr_tag_word_o(ctr_tag_word_o),
    .done_o(done_o), .err_o(err_o)
  );

  int nchk = 0;
  int nerr = 0;
  bit wd_hit = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [127:0] ref_b0(logic [119:0] n, int nl, int tl, logic [31:0] len, bit aad);
    logic [7:0] b [16];
    logic [127:0] r;
    int plen;
    for (int i = 0; i < 16; i++) b[i] = 8'h00;
    b[0] = (aad ? 8'h40 : 8'h00) | 8'((((tl - 2) / 2) & 7) << 3) | 8'(((15 - nl) - 1) & 7);
    for (int i = 0; i < nl; i++) b[i+1] = n[119 - 8*i -: 8];
    plen = 15 - nl;
    if (plen > 4) begin
      b[12] = len[31:24]; b[13] = len[23:16]; b[14] = len[15:8]; b[15] = len[7:0];
    end else begin
      for (int i = nl + 1; i < 16; i++) b[i] = 8'(len >> (8 * (15 - i)));
    end
    for (int i = 0; i < 16; i++) r[127 - 8*i -: 8] = b[i];
    return r;
  endfunction

  function automatic logic [127:0] ref_ctr(logic [127:0] b0, int nl);
    logic [127:0] r = '0;
    r[127:120] = {5'b00000, b0[122:120]};
    for (int i = 1; i <= nl; i++) r[127 - 8*i -: 8] = b0[127 - 8*i -: 8];
    r[0] = 1'b1;
    return r;
  endfunction

  // behavioural reference model, advanced on every rising edge
  bit           m_busy, m_done, m_err, m_acc;
  int           m_cnt;
  logic [127:0] h_b0, h_c0, h_ct, p_b0, p_c0, p_ct;
  string        m_idle_req;

  always @(posedge clk) begin
    bit wb;
    int nl, tl;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_acc = 0; m_cnt = 0;
      h_b0 = '0; h_c0 = '0; h_ct = '0; m_idle_req = "R12";
    end else begin
      wb = m_busy;
      m_done = 0; m_acc = 0;
      if (wb) begin
        if (m_cnt == 15) begin
          m_busy = 0; m_done = 1; h_b0 = p_b0; h_c0 = p_c0; h_ct = p_ct; m_idle_req = "R11";
        end else m_cnt++;
      end else if (req_valid) begin
        m_acc = 1;
        nl = int'(nonce_len_i); tl = int'(tag_len_i);
        if (nl > 15) begin m_err = 1; m_idle_req = "R8"; end
        else if ((tl % 2) != 0 || tl < 4 || tl > 16) begin m_err = 1; m_idle_req = "R9"; end
        else begin
          m_err = 0; m_busy = 1; m_cnt = 0;
          p_b0 = ref_b0(nonce_i, nl, tl, payload_len_i, has_aad_i);
          p_c0 = ref_ctr(p_b0, nl);
          p_ct = p_c0 & ~128'h1;
        end
      end
    end
  end

  always @(posedge clk) word_sel_i <= word_sel_i + 2'd1;

  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      chk(req_ready === !m_busy, "R10 ready", 128'(req_ready), 128'(!m_busy));
      chk(done_o === m_done, "R10 done", 128'(done_o), 128'(m_done));
      chk(err_o === m_err, "R8/R9 err", 128'(err_o), 128'(m_err));
      if (!m_busy) begin
        chk(b0_o === h_b0, {m_idle_req, " b0"}, b0_o, h_b0);
        chk(ctr0_o === h_c0, {m_idle_req, " ctr0"}, ctr0_o, h_c0);
        chk(ctr_tag_o === h_ct, {m_idle_req, " ctrtag"}, ctr_tag_o, h_ct);
        chk(b0_word_o === h_b0[127 - 32*word_sel_i -: 32], "R11 b0 word", 128'(b0_word_o), 128'(h_b0[127 - 32*word_sel_i -: 32]));
        chk(ctr0_word_o === h_c0[127 - 32*word_sel_i -: 32], "R11 ctr0 word", 128'(ctr0_word_o), 128'(h_c0[127 - 32*word_sel_i -: 32]));
        chk(ctr_tag_word_o === h_ct[127 - 32*word_sel_i -: 32], "R11 ctrtag word", 128'(ctr_tag_word_o), 128'(h_ct[127 - 32*word_sel_i -: 32]));
      end
      if (m_done) begin
        chk(b0_o[126] === h_b0[126], "R1 aad flag", 128'(b0_o[126]), 128'(h_b0[126]));
        chk(b0_o[125:123] === h_b0[125:123], "R2 tag field", 128'(b0_o[125:123]), 128'(h_b0[125:123]));
        chk(b0_o[127:120] === h_b0[127:120] && !b0_o[127], "R3 flags", 128'(b0_o[127:120]), 128'(h_b0[127:120]));
        chk(b0_o[119:0] === h_b0[119:0], "R4 R5 body", b0_o, h_b0);
        chk(ctr0_o === h_c0, "R6 counter", ctr0_o, h_c0);
        chk(ctr_tag_o === h_ct, "R7 tag counter", ctr_tag_o, h_ct);
      end
    end
  end

  task automatic send(input logic [119:0] n, input int nl, input int tl, input logic [31:0] len, input bit aad);
    nonce_i = n; nonce_len_i = 5'(nl); tag_len_i = 5'(tl); payload_len_i = len; has_aad_i = aad;
    req_valid = 1'b1;
    do @(negedge clk); while (!m_acc);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy || m_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    wd_hit = 1'b1;
    nchk++; nerr++;
    $display("FAIL R10 watchdog expired actual=hung expected=idle");
    summary();
  end

  localparam logic [119:0] N_A = 120'h0102030405060708090A0B0C0D0E0F;
  localparam logic [119:0] N_B = 120'hA1B2C3D4E5F60718293A4B5C6D7E8F;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; word_sel_i = 2'd0;
    nonce_i = '0; nonce_len_i = '0; tag_len_i = '0; payload_len_i = '0; has_aad_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_ready === 1'b1 && done_o === 1'b0 && err_o === 1'b0, "R12 control", 128'({req_ready, done_o, err_o}), 128'(3'b100));
    chk(b0_o === '0 && ctr0_o === '0 && ctr_tag_o === '0, "R12 blocks", b0_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    send(N_A, 7, 4, 32'h0000_1234, 1'b0);  wait_idle();   // R5 long field, zeros before
    send(N_B, 13, 16, 32'h0000_00AB, 1'b1); wait_idle();  // R1 R2 R5 two-byte field
    send(N_A, 8, 8, 32'hDEAD_BEEF, 1'b1);  wait_idle();   // R5 seven-byte field capped
    send(N_B, 15, 6, 32'h1111_1111, 1'b0); wait_idle();   // R4 R6 full nonce, no length
    send(N_A, 0, 14, 32'h0102_0304, 1'b1); wait_idle();   // R3 empty nonce
    send(N_B, 11, 10, 32'hCAFE_F00D, 1'b0); wait_idle();  // R5 exact four bytes
    send(N_A, 12, 12, 32'h0102_0304, 1'b1); wait_idle();  // R5 three bytes, truncated

    send(N_B, 16, 8, 32'h5555_5555, 1'b1); wait_idle();   // R8 nonce too long
    send(N_B, 31, 4, 32'h5555_5555, 1'b0); wait_idle();   // R8
    send(N_A, 7, 5, 32'h5555_5555, 1'b1);  wait_idle();   // R9 odd tag
    send(N_A, 7, 2, 32'h5555_5555, 1'b1);  wait_idle();   // R9 short tag
    send(N_A, 7, 18, 32'h5555_5555, 1'b1); wait_idle();   // R9 long tag
    send(N_A, 10, 16, 32'h0000_0040, 1'b0); wait_idle();  // R9 err cleared by valid request

    // R10 next request held during build, accepted in the done cycle
    send(N_A, 9, 4, 32'h0001_0000, 1'b1);
    send(N_B, 14, 16, 32'h0000_FFFF, 1'b0);
    wait_idle();
    repeat (4) @(negedge clk);                            // R11 hold while idle
    summary();
  end
endmodule